// File: doc/BRIEF.md
# Sample-Start Pacer

This block paces an analogue-to-digital converter by producing a one-cycle sample-start strobe at a programmable rate. It runs entirely in the system clock domain, which is taken to be the 24 MHz converter reference. A first counter divides that clock by a power of two chosen through a small encoded field. A second counter counts the divided periods and fires the strobe after six times (time unit + 1) of them.

Software programs both fields with a single word write. Any write restarts both counters, so the first strobe after a write lands exactly one full sample period later. A separate clock-down input freezes all counting without losing position, and counting resumes where it stopped once the input is released. A running count of divided periods since the last write is exported so that the division rate can be observed directly.

Top module: `sample_pacer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `sample_tick` is 0 and `div_count` is 0.
- R2: The pre-divide code sits in word bits 31:29. Codes 0 to 5 select a divisor of 4, 8, 16, 32, 64 and 128 system cycles per divided period, and `div_count` advances by one per divided period.
- R3: Codes 6 and 7 in bits 31:29 behave exactly like code 5, with a divisor of 128.
- R4: The time unit `tu` sits in word bits 3:0. One sample period is 6*(tu+1) divided periods, so strobes come every divisor*6*(tu+1) system cycles.
- R5: `sample_tick` is high for exactly one system cycle per sample period.
- R6: A write (`cfg_we` high at a clock edge) clears `div_count` and `sample_tick` at that edge. The next strobe is seen divisor*6*(tu+1) edges after the write edge, and no strobe appears before it.
- R7: While `clk_down` is high, no strobe is produced and `div_count` holds its value. When `clk_down` drops, counting continues from where it stopped, so the strobe is delayed by exactly the number of frozen cycles.
- R8: Word bits 28:4 have no effect on the strobe timing or on `div_count`.
- R9: At the first strobe after a write, `div_count` equals 6*(tu+1). At the second strobe it equals twice that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the converter reference |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing word |
| cfg_wdata | input | 32 | Timing word: divisor code in 31:29, time unit in 3:0 |
| clk_down | input | 1 | Freezes all counting while high |
| sample_tick | output | 1 | One-cycle sample-start strobe |
| div_count | output | 16 | Divided periods since the last write or reset, wrapping |

## Verification
The bench sweeps every divisor code, including the two out-of-range codes, against several time-unit values. It also fills the ignored bits with varying patterns. A design that decoded the code as a raw count, or let codes 6 and 7 wrap to a small divisor, would strobe at the wrong spacing. A period counter off by one would shift both the spacing and the `div_count` reading at the strobe. A write issued mid-period must push the strobe a full new period out; a design that kept the old prescaler phase would strobe early. The freeze test checks that the strobe slips by exactly the frozen cycles. A design that reset its counters on `clk_down`, or kept counting through it, would strobe late or early.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  // Divided periods per unit of the time-unit field
  localparam int SLOTS_PER_UNIT = 6;

  typedef enum logic [2:0] {
    PD_DIV4   = 3'd0,
    PD_DIV8   = 3'd1,
    PD_DIV16  = 3'd2,
    PD_DIV32  = 3'd3,
    PD_DIV64  = 3'd4,
    PD_DIV128 = 3'd5
  } prediv_code_e;

  // Out-of-range codes fold onto the largest legal one
  function automatic int fold_code(input int raw, input int max_code);
    return (raw > max_code) ? max_code : raw;
  endfunction

endpackage

// File: rtl/pacer_cfg.sv
module pacer_cfg #(
  parameter int DATA_W    = 32,
  parameter int CODE_W    = 3,
  parameter int TU_W      = 4,
  parameter int BASE_LOG2 = 2,
  parameter int MAX_CODE  = 5,
  parameter int PD_W      = 7,
  parameter int PER_W     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [PD_W-1:0]   div_last,
  output logic [PER_W-1:0]  per_last
);
  import pacer_pkg::*;

  localparam int CODE_LSB = DATA_W - CODE_W;
  localparam logic [PD_W-1:0] DIV_TOP = PD_W'((1 << (BASE_LOG2 + MAX_CODE)) - 1);

  logic [CODE_W-1:0] code_f;
  logic [TU_W-1:0]   tu_f;
  logic [PD_W-1:0]   div_last_d;
  logic [PER_W-1:0]  per_last_d;

  assign code_f = wdata[DATA_W-1:CODE_LSB];
  assign tu_f   = wdata[TU_W-1:0];

  always_comb begin
    div_last_d = PD_W'((1 << (BASE_LOG2 + fold_code(int'(code_f), MAX_CODE))) - 1);
    per_last_d = PER_W'(SLOTS_PER_UNIT * (int'(tu_f) + 1) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_last <= PD_W'((1 << BASE_LOG2) - 1);
      per_last <= PER_W'(SLOTS_PER_UNIT - 1);
    end else if (we) begin
      div_last <= div_last_d;
      per_last <= per_last_d;
    end
  end

  // R3
  oversize_code_chk: assert property (@(posedge clk) disable iff (rst)
    (we && (int'(code_f) > MAX_CODE)) |=> (div_last == DIV_TOP));

  // R4
  period_floor_chk: assert property (@(posedge clk) disable iff (rst)
    per_last >= PER_W'(SLOTS_PER_UNIT - 1));

endmodule

// File: rtl/pacer_prediv.sv
module pacer_prediv #(
  parameter int PD_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            hold,
  input  logic [PD_W-1:0] div_last,
  output logic            step
);
  logic [PD_W-1:0] phase;

  assign step = !hold && (phase == div_last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
    end else if (!hold) begin
      phase <= step ? '0 : phase + 1'b1;
    end
  end

  // R2
  phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= div_last);

  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !restart) |=> $stable(phase));

endmodule

// File: rtl/pacer_period.sv
module pacer_period #(
  parameter int PER_W = 7,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             hold,
  input  logic             step,
  input  logic [PER_W-1:0] per_last,
  output logic             tick,
  output logic [CNT_W-1:0] div_count
);
  logic [PER_W-1:0] slot;
  logic             wrap;

  assign wrap = step && (slot == per_last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      slot      <= '0;
      tick      <= 1'b0;
      div_count <= '0;
    end else begin
      tick <= wrap;
      if (step) begin
        slot      <= wrap ? '0 : slot + 1'b1;
        div_count <= div_count + 1'b1;
      end
    end
  end

  // R5
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R6
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!tick && div_count == '0));

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !restart) |=> (!tick && $stable(div_count)));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (div_count == $past(div_count) || div_count == $past(div_count) + 1'b1));

  // R4
  slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
    slot <= per_last);

endmodule

// File: rtl/sample_pacer.sv
module sample_pacer #(
  parameter int DATA_W    = 32,
  parameter int CODE_W    = 3,
  parameter int TU_W      = 4,
  parameter int BASE_LOG2 = 2,
  parameter int MAX_CODE  = 5,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              clk_down,
  output logic              sample_tick,
  output logic [CNT_W-1:0]  div_count
);
  import pacer_pkg::*;

  localparam int DIV_MAX = 1 << (BASE_LOG2 + MAX_CODE);
  localparam int PD_W    = $clog2(DIV_MAX);
  localparam int PER_MAX = SLOTS_PER_UNIT * (1 << TU_W);
  localparam int PER_W   = $clog2(PER_MAX);

  logic [PD_W-1:0]  div_last;
  logic [PER_W-1:0] per_last;
  logic             step;

  pacer_cfg #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .TU_W(TU_W),
    .BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE),
    .PD_W(PD_W), .PER_W(PER_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .div_last(div_last), .per_last(per_last)
  );

  pacer_prediv #(.PD_W(PD_W)) u_prediv (
    .clk(clk), .rst(rst), .restart(cfg_we), .hold(clk_down),
    .div_last(div_last), .step(step)
  );

  pacer_period #(.PER_W(PER_W), .CNT_W(CNT_W)) u_period (
    .clk(clk), .rst(rst), .restart(cfg_we), .hold(clk_down),
    .step(step), .per_last(per_last),
    .tick(sample_tick), .div_count(div_count)
  );

endmodule

// File: tb/sample_pacer_bench.sv
module sample_pacer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        clk_down = 1'b0;
  logic        sample_tick;
  logic [15:0] div_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sample_pacer u_sample_pacer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .clk_down(clk_down), .sample_tick(sample_tick), .div_count(div_count)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Leaves the bench at the falling edge right after the write edge
  task automatic wr(input int code, input int tu, input int junk);
    @(negedge clk);
    cfg_wdata = (32'(code) << 29) | (32'(junk) & 32'h1FFF_FFF0) | 32'(tu & 15);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_tick(output int k, input int limit);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!sample_tick && k < limit);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int k;
    int ticks;
    repeat (3) @(negedge clk);
    check("R1 tick in reset", sample_tick, 0);
    check("R1 count in reset", div_count, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tick after reset", sample_tick, 0);
    check("R1 count after reset", div_count, 0);

    // Sweep: R2 R3 R4 R5 R6 R8 R9
    for (int code = 0; code < 8; code++) begin
      for (int tu = 0; tu < 4; tu++) begin
        int dv;
        int per;
        int n;
        dv  = 4 << ((code > 5) ? 5 : code);
        per = 6 * (tu + 1);
        n   = dv * per;
        wr(code, tu, 32'h0A5C_3E70 ^ (code * 32'h0111_1110) ^ (tu * 32'h0030_0C00));
        check("R6 count cleared by write", div_count, 0);
        check("R6 tick cleared by write", sample_tick, 0);
        wait_tick(k, n + 8);
        check((code > 5) ? "R3 first strobe spacing" : "R2 R4 R8 first strobe spacing", k, n);
        check("R9 count at first strobe", div_count, per);
        wait_tick(k, n + 8);
        check("R4 second strobe spacing", k, n);
        check("R9 count at second strobe", div_count, 2 * per);
        @(negedge clk);
        check("R5 strobe width", sample_tick, 0);
      end
    end

    // Largest time unit, smallest divisor: R4
    wr(0, 15, 0);
    wait_tick(k, 400);
    check("R4 tu=15 spacing", k, 384);
    check("R9 tu=15 count", div_count, 96);

    // Freeze: R7
    wr(0, 0, 0);
    repeat (10) @(negedge clk);
    check("R7 count before freeze", div_count, 2);
    clk_down = 1'b1;
    ticks = 0;
    repeat (50) begin
      @(negedge clk);
      if (sample_tick) ticks++;
    end
    check("R7 no strobe while frozen", ticks, 0);
    check("R7 count held while frozen", div_count, 2);
    clk_down = 1'b0;
    wait_tick(k, 100);
    check("R7 strobe after thaw", k, 14);
    check("R7 count after thaw", div_count, 6);

    // Mid-period rewrite: R6
    wr(0, 0, 0);
    repeat (10) @(negedge clk);
    wr(1, 0, 0);
    check("R6 count cleared mid-period", div_count, 0);
    wait_tick(k, 60);
    check("R6 strobe after rewrite", k, 48);

    done = 1'b1;
    finish_run();
  end
endmodule